// File: doc/BRIEF.md
# PCIe Memory-Write Register Decoder

This block sits on the user side of a PCIe endpoint's receive stream. Each cycle it can take one 32-bit doubleword. Valid, start-of-packet and end-of-packet strobes qualify each doubleword. A receive state machine walks the three header doublewords of each transaction layer packet. When the packet is a single-doubleword memory write with 32-bit addressing, the machine takes the register index from the address and the byte enables from the second header word. The payload doubleword is then merged, byte lane by byte lane, into a small register file.

The register file spans a 256-byte window of 64 doubleword registers. Register 0 drives a general-purpose output bus. A registered read port exposes any register so that the surrounding logic can use it. Any packet that is not a plain single-doubleword write is discarded up to its end-of-packet strobe without touching the registers. This covers other formats and types, other lengths, poisoned payloads and bad last-byte enables.

Top module: `tlp_regwr_decoder`

## Requirements
- R1: After synchronous reset, every register, `gpio_out` and `rd_data` read 0.
- R2: A packet is accepted as a write when all of these hold: Fmt = 2'b10, Type = 5'b00000, Length = 1, EP = 0 and Last BE = 4'b0000. The packet consists of start-of-packet header word 0, header word 1, header word 2 and one payload word. An accepted packet updates register `addr[7:2]`.
- R3: Field positions in header word 0: Fmt is `[30:29]`, Type is `[28:24]`, EP is `[14]` and Length is `[9:0]`. In header word 1, Last BE is `[7:4]` and First BE is `[3:0]`. In header word 2, bits `[7:2]` select the register, and bits `[31:8]` and `[1:0]` are ignored.
- R4: When First BE bit i is set, payload bits `[8i+7:8i]` are written into the same lanes of the register. When the bit is clear, that lane keeps its value; First BE = 0 writes nothing.
- R5: A packet with any other Fmt or Type changes no register. Examples are Fmt 2'b00, Fmt 2'b11 and Type 5'b00100.
- R6: A packet whose Length is not 1 changes no register. Its remaining beats are skipped up to end-of-packet.
- R7: A packet with EP = 1 changes no register.
- R8: A packet with a non-zero Last BE changes no register.
- R9: A start-of-packet beat arriving in the middle of a packet discards the partial packet. Parsing restarts on that beat, and the new packet is handled normally.
- R10: An end-of-packet strobe before the payload returns the parser to idle with no write. Beats without start-of-packet that arrive while idle are ignored.
- R11: Cycles with `rx_valid` low are ignored whatever `rx_sop`, `rx_eop` and `rx_data` carry, and parsing resumes on the next valid beat.
- R12: A write to register 0 appears on `gpio_out` after the second rising edge that follows the edge accepting the payload beat.
- R13: `rd_data` shows the register selected by `rd_idx` one rising edge after `rd_idx` is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive beat qualifier |
| rx_sop | input | 1 | First beat of a packet |
| rx_eop | input | 1 | Last beat of a packet |
| rx_data | input | 32 | Receive doubleword |
| rd_idx | input | 6 | Register index for the read port |
| rd_data | output | 32 | Registered contents of register `rd_idx` |
| gpio_out | output | 32 | Registered copy of register 0 |

## Verification
Suppose the parser keeps a stale state after a restart or truncation. The next packet is then either mis-parsed or dropped. That shows up on the read port within a few cycles of the packet as a wrong or missing value in the targeted register. A lane-mask or index fault corrupts bytes of a specific register and is visible on the next read of it. A flaw in the reject path lets a discarded packet leak into a register, which a read-back right after that packet exposes. Timing errors in the write staging or output registers shift the `gpio_out` change by one edge, and the edge-exact checks catch that.

// File: rtl/tlpdec_pkg.sv
package tlpdec_pkg;

  // Header word 0 field positions
  localparam int H0_FMT_HI   = 30;
  localparam int H0_FMT_LO   = 29;
  localparam int H0_TYPE_HI  = 28;
  localparam int H0_TYPE_LO  = 24;
  localparam int H0_EP_BIT   = 14;
  localparam int H0_LEN_HI   = 9;
  localparam int H0_LEN_LO   = 0;

  // Header word 1 field positions
  localparam int H1_LBE_HI   = 7;
  localparam int H1_LBE_LO   = 4;
  localparam int H1_FBE_HI   = 3;
  localparam int H1_FBE_LO   = 0;

  // Header word 2: doubleword address starts at bit 2
  localparam int H2_ADDR_LO  = 2;

  localparam logic [1:0] FMT_3DW_DATA = 2'b10;
  localparam logic [4:0] TYPE_MEM     = 5'b00000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR1,
    ST_HDR2,
    ST_PAYLD,
    ST_DRAIN
  } rx_state_e;

endpackage

// File: rtl/tlpdec_rx_fsm.sv
module tlpdec_rx_fsm
  import tlpdec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [DATA_W-1:0] rx_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BE_W-1:0]   wr_be,
  output logic [DATA_W-1:0] wr_data
);

  rx_state_e        st;
  logic [BE_W-1:0]  be_q;
  logic [IDX_W-1:0] idx_q;

  logic hdr0_ok;
  logic lbe_zero;

  always_comb begin
    hdr0_ok = (rx_data[H0_FMT_HI:H0_FMT_LO] == FMT_3DW_DATA)
           && (rx_data[H0_TYPE_HI:H0_TYPE_LO] == TYPE_MEM)
           && (rx_data[H0_LEN_HI:H0_LEN_LO] == 10'd1)
           && !rx_data[H0_EP_BIT];
    lbe_zero = (rx_data[H1_LBE_HI:H1_LBE_LO] == 4'b0000);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      be_q    <= '0;
      idx_q   <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_be   <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (rx_valid) begin
        if (rx_sop) begin
          if (rx_eop)       st <= ST_IDLE;
          else if (hdr0_ok) st <= ST_HDR1;
          else              st <= ST_DRAIN;
        end else begin
          unique case (st)
            ST_IDLE: st <= ST_IDLE;
            ST_HDR1: begin
              be_q <= rx_data[H1_FBE_HI:H1_FBE_LO];
              if (rx_eop)        st <= ST_IDLE;
              else if (lbe_zero) st <= ST_HDR2;
              else               st <= ST_DRAIN;
            end
            ST_HDR2: begin
              idx_q <= rx_data[H2_ADDR_LO +: IDX_W];
              st    <= rx_eop ? ST_IDLE : ST_PAYLD;
            end
            ST_PAYLD: begin
              wr_en   <= 1'b1;
              wr_idx  <= idx_q;
              wr_be   <= be_q;
              wr_data <= rx_data;
              st      <= rx_eop ? ST_IDLE : ST_DRAIN;
            end
            ST_DRAIN: if (rx_eop) st <= ST_IDLE;
            default:  st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R2: a staged write exists only after a valid payload beat in the payload state
  a_r2_write_after_payload: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(st == ST_PAYLD && rx_valid && !rx_sop));

  // R9: a start beat always restarts header parsing
  a_r9_sop_restarts: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sop && !rx_eop) |=> (st == ST_HDR1 || st == ST_DRAIN));

  // R10: end-of-packet always lands in idle
  a_r10_eop_to_idle: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_eop) |=> (st == ST_IDLE));

  // R11: idle stream cycles leave the parser untouched
  a_r11_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(st) && !wr_en);

  // R7: a poisoned header never enters header parsing
  a_r7_poison_drained: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sop && !rx_eop && rx_data[H0_EP_BIT]) |=> (st == ST_DRAIN));

endmodule

// File: rtl/tlpdec_regfile.sv
module tlpdec_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 64,
  localparam int IDX_W = $clog2(NREG),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] gpio_out
);

  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) mem[r] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < BE_W; b++)
        if (wr_be[b]) mem[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      gpio_out <= '0;
    end else begin
      rd_data  <= mem[rd_idx];
      gpio_out <= mem[0];
    end
  end

  // R4: a cleared byte enable keeps that lane of the target register
  for (genvar g = 0; g < BE_W; g++) begin : g_lane_chk
    a_r4_lane_kept: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_be[g]) |=> mem[$past(wr_idx)][g*8 +: 8] == $past(mem[wr_idx][g*8 +: 8]));
  end

  // R12: the output bus follows register 0 one edge later
  a_r12_gpio_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> gpio_out == $past(mem[0]));

  // R13: read data is the register addressed on the previous edge
  a_r13_read_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_data == $past(mem[rd_idx]));

endmodule

// File: rtl/tlp_regwr_decoder.sv
module tlp_regwr_decoder #(
  parameter int DATA_W = 32,
  parameter int NREG   = 64,
  localparam int IDX_W = $clog2(NREG),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] gpio_out
);

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BE_W-1:0]   wr_be;
  logic [DATA_W-1:0] wr_data;

  tlpdec_rx_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rx_fsm (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_sop   (rx_sop),
    .rx_eop   (rx_eop),
    .rx_data  (rx_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_be    (wr_be),
    .wr_data  (wr_data)
  );

  tlpdec_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_regfile (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .gpio_out (gpio_out)
  );

endmodule

// File: tb/tlp_regwr_decoder_bench.sv
module tlp_regwr_decoder_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_valid, rx_sop, rx_eop;
  logic [31:0] rx_data;
  logic [5:0]  rd_idx;
  logic [31:0] rd_data, gpio_out;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  logic [31:0] shadow [64];

  always #10 clk = ~clk;

  tlp_regwr_decoder u_tlp_regwr_decoder (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_data(rx_data), .rd_idx(rd_idx), .rd_data(rd_data), .gpio_out(gpio_out)
  );

  // {hdr0, hdr1, hdr2, payload}
  localparam logic [127:0] VEC [11] = '{
    {32'h4000_0001, 32'h0000_010F, 32'hDC00_000C, 32'h1234_5678}, // R2 full write idx 3
    {32'h4000_0001, 32'h0000_0101, 32'hDC00_000C, 32'hAABB_CCDD}, // R4 lane 0 only
    {32'h4000_0001, 32'h0000_010A, 32'hDC00_000C, 32'h1122_3344}, // R4 lanes 1 and 3
    {32'h0000_0001, 32'h0000_010F, 32'hDC00_000C, 32'hFFFF_FFFF}, // R5 fmt 00
    {32'h4000_4001, 32'h0000_010F, 32'hDC00_000C, 32'hEEEE_EEEE}, // R7 poisoned
    {32'h4000_0001, 32'h0000_01FF, 32'hDC00_000C, 32'hDDDD_DDDD}, // R8 last BE set
    {32'h6000_0001, 32'h0000_010F, 32'hDC00_000C, 32'hCCCC_CCCC}, // R5 fmt 11
    {32'h4400_0001, 32'h0000_010F, 32'hDC00_000C, 32'hBBBB_BBBB}, // R5 type 00100
    {32'h4000_0001, 32'h0000_010F, 32'hDC00_00FC, 32'h5A5A_5A5A}, // R3 top index
    {32'h4000_0001, 32'h0000_0100, 32'hDC00_0010, 32'h9999_9999}, // R4 no lanes
    {32'h4000_0001, 32'h0000_0106, 32'hFFFF_FF17, 32'h0102_0304}  // R3 upper/low addr bits ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of the requirements
  task automatic model(input logic [31:0] h0, input logic [31:0] h1,
                       input logic [31:0] h2, input logic [31:0] d);
    bit ok;
    ok = (h0[30:29] == 2'b10) && (h0[28:24] == 5'd0) && (h0[9:0] == 10'd1)
      && !h0[14] && (h1[7:4] == 4'd0);
    if (ok)
      for (int b = 0; b < 4; b++)
        if (h1[b]) shadow[h2[7:2]][b*8 +: 8] = d[b*8 +: 8];
  endtask

  task automatic beat(input logic [31:0] d, input logic s, input logic e);
    rx_valid = 1'b1; rx_sop = s; rx_eop = e; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_data = '0;
  endtask

  task automatic gap();
    rx_valid = 1'b0; rx_sop = 1'b1; rx_eop = 1'b1; rx_data = 32'hFFFF_FFFF;
    @(negedge clk);
    rx_sop = 1'b0; rx_eop = 1'b0; rx_data = '0;
  endtask

  task automatic send(input logic [31:0] h0, input logic [31:0] h1,
                      input logic [31:0] h2, input logic [31:0] d);
    beat(h0, 1'b1, 1'b0);
    beat(h1, 1'b0, 1'b0);
    beat(h2, 1'b0, 1'b0);
    beat(d,  1'b0, 1'b1);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] i, output logic [31:0] v);
    rd_idx = i;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int r = 0; r < 64; r++) shadow[r] = '0;
    rst = 1'b1; rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_data = '0; rd_idx = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 gpio", gpio_out, 32'h0);
    rd(6'd5, v);
    check("R1 reg5", v, 32'h0);

    // R12: gpio edge timing for a write to register 0
    beat(32'h4000_0001, 1'b1, 1'b0);
    beat(32'h0000_010F, 1'b0, 1'b0);
    beat(32'hDC00_0000, 1'b0, 1'b0);
    beat(32'hCAFE_F00D, 1'b0, 1'b1);   // returns after the accepting edge
    model(32'h4000_0001, 32'h0000_010F, 32'hDC00_0000, 32'hCAFE_F00D);
    @(negedge clk);
    check("R12 gpio after first edge", gpio_out, 32'h0);
    @(negedge clk);
    check("R12 gpio after second edge", gpio_out, 32'hCAFE_F00D);

    // Vector table: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < 11; i++) begin
      logic [31:0] h0, h1, h2, d;
      {h0, h1, h2, d} = VEC[i];
      send(h0, h1, h2, d);
      model(h0, h1, h2, d);
      settle();
      rd(h2[7:2], v);
      check($sformatf("R2/R3/R4/R5/R7/R8 vector %0d", i), v, shadow[h2[7:2]]);
    end

    // R13: read port latency, one edge after rd_idx changes
    rd_idx = 6'd63;
    @(negedge clk);
    check("R13 read idx 63", rd_data, shadow[63]);
    rd_idx = 6'd3;
    @(negedge clk);
    check("R13 read idx 3", rd_data, shadow[3]);

    // R6: length 2 packet is skipped entirely
    beat(32'h4000_0002, 1'b1, 1'b0);
    beat(32'h0000_010F, 1'b0, 1'b0);
    beat(32'hDC00_0028, 1'b0, 1'b0);
    beat(32'h1111_1111, 1'b0, 1'b0);
    beat(32'h2222_2222, 1'b0, 1'b1);
    settle();
    rd(6'd10, v);
    check("R6 length 2 ignored", v, 32'h0);

    // R9: restart mid-header, second packet lands
    beat(32'h4000_0001, 1'b1, 1'b0);
    beat(32'h0000_010F, 1'b0, 1'b0);
    send(32'h4000_0001, 32'h0000_010F, 32'hDC00_001C, 32'h7777_0007);
    model(32'h4000_0001, 32'h0000_010F, 32'hDC00_001C, 32'h7777_0007);
    settle();
    rd(6'd7, v);
    check("R9 restart", v, 32'h7777_0007);

    // R9: restart in place of the payload beat
    beat(32'h4000_0001, 1'b1, 1'b0);
    beat(32'h0000_010F, 1'b0, 1'b0);
    beat(32'hDC00_0030, 1'b0, 1'b0);
    send(32'h4000_0001, 32'h0000_0103, 32'hDC00_0030, 32'hABCD_1234);
    model(32'h4000_0001, 32'h0000_0103, 32'hDC00_0030, 32'hABCD_1234);
    settle();
    rd(6'd12, v);
    check("R9 restart at payload", v, 32'h0000_1234);

    // R10: truncated header, then stray beats while idle
    beat(32'h4000_0001, 1'b1, 1'b0);
    beat(32'h0000_010F, 1'b0, 1'b1);
    beat(32'hDC00_0020, 1'b0, 1'b0);
    beat(32'h1111_1111, 1'b0, 1'b1);
    settle();
    rd(6'd8, v);
    check("R10 truncated no write", v, 32'h0);
    send(32'h4000_0001, 32'h0000_010F, 32'hDC00_0020, 32'h0808_0808);
    model(32'h4000_0001, 32'h0000_010F, 32'hDC00_0020, 32'h0808_0808);
    settle();
    rd(6'd8, v);
    check("R10 next packet parsed", v, 32'h0808_0808);

    // R11: invalid cycles carrying junk strobes between beats
    beat(32'h4000_0001, 1'b1, 1'b0); gap();
    beat(32'h0000_010F, 1'b0, 1'b0); gap(); gap();
    beat(32'hDC00_002C, 1'b0, 1'b0); gap();
    beat(32'h1111_2222, 1'b0, 1'b1);
    model(32'h4000_0001, 32'h0000_010F, 32'hDC00_002C, 32'h1111_2222);
    settle();
    rd(6'd11, v);
    check("R11 stalls ignored", v, 32'h1111_2222);

    // R12: gpio still reflects register 0 after all traffic
    check("R12 gpio final", gpio_out, shadow[0]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule